// File: doc/BRIEF.md
# Tiled 2-D buffer address generator

This block produces the linear sample addresses a DMA engine needs to move a 2-D sample buffer as a series of rectangular tiles. Software-side logic presents a configuration on the input pins: the row pitch of the buffer, the tile extent in both dimensions, a 2-D starting offset, and two traversal steps. Each step names a dimension, a stride and a wrap count. A start pulse loads that configuration, and the block then issues one address per accepted cycle on a valid/ready interface.

Inside a tile, dimension 0 (the contiguous direction) is the innermost loop and dimension 1 is the next loop out. Tile origins come from the two traversal steps. Step 0 is the faster-changing tile loop and step 1 is the slower one. Either step may drive either dimension, so tiles can be walked row-wise or column-wise. A stride smaller than the tile extent makes neighbouring tiles overlap. The block flags the final sample of every tile and the final sample of the whole transfer, and then it goes idle.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, valid_o, tile_last_o and done_o are low.
- R2: A start_i pulse seen while idle loads all configuration inputs. valid_o is high from the next cycle onward, and the first address is off1_i*row_pitch_i + off0_i.
- R3: Within a tile, samples are issued with the dimension-0 index x running fastest from 0 to tile_w_i-1, and then the dimension-1 index y runs from 0 to tile_h_i-1.
- R4: Tile index k of step s (where k runs from 0 to wrap-1) contributes k*stride to the origin of the dimension selected by that step's dim input (0 means dimension 0, 1 means dimension 1). Step 0 is the inner tile loop and step 1 the outer one, so both row-wise and column-wise orders can be produced.
- R5: When a stride is smaller than the tile extent, tiles overlap and the same addresses are issued again for each tile that covers them.
- R6: The address is ((off1 + org1 + y) * row_pitch + off0 + org0 + x) modulo 2^ADDR_W.
- R7: The sequence advances only on a cycle where valid_o and ready_i are both high. While ready_i is low, addr_o and the flags hold steady.
- R8: tile_last_o is high exactly on the final sample of each tile.
- R9: done_o is high exactly on the final sample of the last tile, and it is always accompanied by tile_last_o. The transfer holds (tile_w*tile_h*wrap0*wrap1) samples, and valid_o is low in the cycle after that sample is accepted.
- R10: While busy, a start_i pulse and any change on the configuration inputs have no effect on the running sequence.
- R11: A tile extent or wrap count of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; only acted on while idle |
| row_pitch_i | input | DIM_W | Buffer extent along dimension 0 (the row length in samples) |
| tile_w_i | input | DIM_W | Tile extent along dimension 0 |
| tile_h_i | input | DIM_W | Tile extent along dimension 1 |
| off0_i | input | DIM_W | Start offset along dimension 0 |
| off1_i | input | DIM_W | Start offset along dimension 1 |
| step0_dim_i | input | 1 | Dimension moved by the inner tile step |
| step0_stride_i | input | DIM_W | Stride of the inner tile step |
| step0_wrap_i | input | DIM_W | Tile count of the inner tile step |
| step1_dim_i | input | 1 | Dimension moved by the outer tile step |
| step1_stride_i | input | DIM_W | Stride of the outer tile step |
| step1_wrap_i | input | DIM_W | Tile count of the outer tile step |
| ready_i | input | 1 | Consumer accepts the current address |
| valid_o | output | 1 | Address is valid; high for the whole transfer |
| addr_o | output | ADDR_W | Linear sample address |
| tile_last_o | output | 1 | Final sample of the current tile |
| done_o | output | 1 | Final sample of the transfer |

## Verification
The end of a tile and the end of the whole transfer fall on the same sample. In that cycle tile_last_o and done_o must rise together, and valid_o must drop on the following edge. Back-pressure can hold that final sample for several cycles, and a start pulse can arrive in the very cycle it is accepted. Random ready patterns and random start pulses during busy periods provoke both situations. Each sample's address and flags are compared against a nested-loop model in the bench, and valid_o must read low in the cycle after the final handshake, with no relaunch.

// File: rtl/tile_agen_pkg.sv
package tile_agen_pkg;
  localparam int unsigned NUM_LOOPS = 4;
  localparam int unsigned NUM_STEPS = 2;
  // loop nesting, innermost first
  localparam int unsigned LP_X  = 0;
  localparam int unsigned LP_Y  = 1;
  localparam int unsigned LP_T0 = 2;
  localparam int unsigned LP_T1 = 3;
endpackage

// File: rtl/tile_loop_cnt.sv
module tile_loop_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  // limit 0 behaves as 1
  assign last_o = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, limit_i};
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= last_o ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/tile_addr_calc.sv
module tile_addr_calc
  import tile_agen_pkg::*;
#(
  parameter int unsigned DIM_W  = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic [DIM_W-1:0]                x_i,
  input  logic [DIM_W-1:0]                y_i,
  input  logic [NUM_STEPS-1:0][DIM_W-1:0] idx_i,
  input  logic [NUM_STEPS-1:0][DIM_W-1:0] stride_i,
  input  logic [NUM_STEPS-1:0]            sel_i,
  input  logic [DIM_W-1:0]                off0_i,
  input  logic [DIM_W-1:0]                off1_i,
  input  logic [DIM_W-1:0]                pitch_i,
  output logic [ADDR_W-1:0]               addr_o
);
  logic [ADDR_W-1:0] org0, org1, prod, col, row;

  always_comb begin
    org0 = '0;
    org1 = '0;
    for (int s = 0; s < NUM_STEPS; s++) begin
      prod = ADDR_W'(idx_i[s]) * ADDR_W'(stride_i[s]);
      if (sel_i[s]) org1 = org1 + prod;
      else          org0 = org0 + prod;
    end
    col    = ADDR_W'(off0_i) + org0 + ADDR_W'(x_i);
    row    = ADDR_W'(off1_i) + org1 + ADDR_W'(y_i);
    addr_o = row * ADDR_W'(pitch_i) + col;
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_agen_pkg::*;
#(
  parameter int unsigned DIM_W  = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  row_pitch_i,
  input  logic [DIM_W-1:0]  tile_w_i,
  input  logic [DIM_W-1:0]  tile_h_i,
  input  logic [DIM_W-1:0]  off0_i,
  input  logic [DIM_W-1:0]  off1_i,
  input  logic              step0_dim_i,
  input  logic [DIM_W-1:0]  step0_stride_i,
  input  logic [DIM_W-1:0]  step0_wrap_i,
  input  logic              step1_dim_i,
  input  logic [DIM_W-1:0]  step1_stride_i,
  input  logic [DIM_W-1:0]  step1_wrap_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tile_last_o,
  output logic              done_o
);
  logic                            active_q;
  logic [DIM_W-1:0]                pitch_q, off0_q, off1_q;
  logic [NUM_STEPS-1:0]            sel_q;
  logic [NUM_STEPS-1:0][DIM_W-1:0] stride_q;
  logic [NUM_LOOPS-1:0][DIM_W-1:0] limit_q;
  logic [NUM_LOOPS-1:0][DIM_W-1:0] cnt;
  logic [NUM_LOOPS-1:0]            last, inc;
  logic                            launch, hs;

  assign launch = start_i & ~active_q;
  assign hs     = active_q & ready_i;

  // config captured only on launch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pitch_q  <= '0;
      off0_q   <= '0;
      off1_q   <= '0;
      sel_q    <= '0;
      stride_q <= '0;
      limit_q  <= '0;
    end else if (launch) begin
      pitch_q         <= row_pitch_i;
      off0_q          <= off0_i;
      off1_q          <= off1_i;
      sel_q           <= {step1_dim_i, step0_dim_i};
      stride_q        <= {step1_stride_i, step0_stride_i};
      limit_q[LP_X]   <= tile_w_i;
      limit_q[LP_Y]   <= tile_h_i;
      limit_q[LP_T0]  <= step0_wrap_i;
      limit_q[LP_T1]  <= step1_wrap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            active_q <= 1'b0;
    else if (launch)        active_q <= 1'b1;
    else if (hs && done_o)  active_q <= 1'b0;
  end

  // carry chain: each loop steps when all inner loops wrap
  assign inc[0] = hs;
  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    if (g > 0) begin : g_carry
      assign inc[g] = inc[g-1] & last[g-1];
    end
    tile_loop_cnt #(.W(DIM_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (launch),
      .inc_i  (inc[g]),
      .limit_i(limit_q[g]),
      .cnt_o  (cnt[g]),
      .last_o (last[g])
    );
  end

  tile_addr_calc #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_calc (
    .x_i     (cnt[LP_X]),
    .y_i     (cnt[LP_Y]),
    .idx_i   ({cnt[LP_T1], cnt[LP_T0]}),
    .stride_i(stride_q),
    .sel_i   (sel_q),
    .off0_i  (off0_q),
    .off1_i  (off1_q),
    .pitch_i (pitch_q),
    .addr_o  (addr_o)
  );

  assign valid_o     = active_q;
  assign tile_last_o = active_q & last[LP_X] & last[LP_Y];
  assign done_o      = tile_last_o & last[LP_T0] & last[LP_T1];
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              tile_last_o,
  input logic              done_o
);
  AST_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_o |=> valid_o); // R2
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(tile_last_o) && $stable(done_o)); // R7
  AST_FLAGS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !tile_last_o && !done_o); // R8
  AST_DONE_IN_TILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tile_last_o); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && done_o |=> !valid_o); // R9
  AST_BUSY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !(ready_i && done_o) |=> valid_o); // R10
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ready_i    (ready_i),
  .valid_o    (valid_o),
  .addr_o     (addr_o),
  .tile_last_o(tile_last_o),
  .done_o     (done_o)
);

// File: tb/tile_addr_gen_tb.sv
`timescale 1ns/1ps
module tile_addr_gen_tb;
  localparam int DIM_W  = 8;
  localparam int ADDR_W = 16;
  localparam int MAXN   = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b0;
  logic [DIM_W-1:0] pitch = '0, tw = '0, th = '0, o0 = '0, o1 = '0;
  logic s0d = 1'b0, s1d = 1'b0;
  logic [DIM_W-1:0] s0s = '0, s0w = '0, s1s = '0, s1w = '0;
  logic valid, tlast, done;
  logic [ADDR_W-1:0] addr;

  int n_run = 0, n_fail = 0;
  int exp_addr [MAXN];
  bit exp_tl   [MAXN];
  bit exp_dn   [MAXN];
  int exp_n;

  always #2 clk = ~clk;

  tile_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .row_pitch_i(pitch), .tile_w_i(tw), .tile_h_i(th),
    .off0_i(o0), .off1_i(o1),
    .step0_dim_i(s0d), .step0_stride_i(s0s), .step0_wrap_i(s0w),
    .step1_dim_i(s1d), .step1_stride_i(s1s), .step1_wrap_i(s1w),
    .ready_i(ready), .valid_o(valid), .addr_o(addr),
    .tile_last_o(tlast), .done_o(done)
  );

  function automatic int atl1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // reference: step1 outer, step0, y, x innermost (R3 R4 R6 R11)
  task automatic build_exp(int ctw, int cth, int co0, int co1, int cp,
                           int d0, int st0, int w0, int d1, int st1, int w1);
    int w0e = atl1(w0), w1e = atl1(w1), twe = atl1(ctw), the = atl1(cth);
    exp_n = 0;
    for (int i1 = 0; i1 < w1e; i1++)
      for (int i0 = 0; i0 < w0e; i0++)
        for (int y = 0; y < the; y++)
          for (int x = 0; x < twe; x++) begin
            int g0 = (d0 == 0 ? i0*st0 : 0) + (d1 == 0 ? i1*st1 : 0);
            int g1 = (d0 == 1 ? i0*st0 : 0) + (d1 == 1 ? i1*st1 : 0);
            exp_addr[exp_n] = ((co1 + g1 + y) * cp + co0 + g0 + x) & 32'hFFFF;
            exp_tl[exp_n]   = (x == twe-1) && (y == the-1);
            exp_dn[exp_n]   = exp_tl[exp_n] && (i0 == w0e-1) && (i1 == w1e-1);
            exp_n++;
          end
  endtask

  task automatic run_case(string tag, int ctw, int cth, int co0, int co1, int cp,
                          int d0, int st0, int w0, int d1, int st1, int w1,
                          int rdy_pct, bit busy_noise);
    int k = 0;
    build_exp(ctw, cth, co0, co1, cp, d0, st0, w0, d1, st1, w1);
    @(negedge clk);
    pitch = DIM_W'(cp); tw = DIM_W'(ctw); th = DIM_W'(cth);
    o0 = DIM_W'(co0); o1 = DIM_W'(co1);
    s0d = d0[0]; s0s = DIM_W'(st0); s0w = DIM_W'(w0);
    s1d = d1[0]; s1s = DIM_W'(st1); s1w = DIM_W'(w1);
    start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(valid === 1'b1 && addr === ADDR_W'(exp_addr[0]), {tag, " R2 launch"}, int'(addr), exp_addr[0]);
    if (busy_noise) begin // R10: scramble config while busy
      pitch = DIM_W'($urandom); tw = DIM_W'($urandom); o0 = DIM_W'($urandom);
      s0s = DIM_W'($urandom); s1w = DIM_W'($urandom); s0d = ~s0d;
    end
    while (k < exp_n) begin
      check(valid === 1'b1 && addr === ADDR_W'(exp_addr[k]),
            {tag, " R3/R4/R5/R6/R7/R10 addr"}, int'(addr), exp_addr[k]);
      check(tlast === exp_tl[k] && done === exp_dn[k],
            {tag, " R8/R9 flags"}, {tlast, done}, {exp_tl[k], exp_dn[k]});
      ready = (($urandom % 100) < rdy_pct);
      start = busy_noise && (($urandom % 4) == 0);
      if (ready) k++;
      @(negedge clk);
    end
    start = 1'b0; ready = 1'b0;
    check(valid === 1'b0 && tlast === 1'b0 && done === 1'b0, {tag, " R9 idle"}, valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(valid === 1'b0 && tlast === 1'b0 && done === 1'b0, "R1 reset", {valid, tlast, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid === 1'b0, "R1 after release", valid, 0);
    // R4 column-wise: inner step moves dim1
    run_case("colwise", 4, 3, 0, 0, 12, 1, 3, 2, 0, 4, 3, 100, 1'b0);
    // R5 row-wise with overlap in dim0, back-pressure
    run_case("rowwise_overlap", 7, 2, 0, 0, 12, 0, 5, 2, 1, 2, 3, 60, 1'b1);
    // R6 offsets, heavy back-pressure
    run_case("offset", 3, 2, 2, 1, 20, 0, 3, 3, 1, 4, 2, 25, 1'b1);
    // R11 zero extents and wraps act as 1
    run_case("zero_lim", 0, 2, 1, 0, 9, 0, 2, 0, 1, 3, 2, 70, 1'b0);
    // single-sample transfer: tile_last and done together
    run_case("single", 1, 1, 5, 3, 10, 0, 1, 1, 1, 1, 1, 50, 1'b1);
    for (int r = 0; r < 25; r++) begin
      run_case("rand", 1 + $urandom % 6, 1 + $urandom % 6, $urandom % 8, $urandom % 8,
               8 + $urandom % 33, $urandom % 2, $urandom % 8, 1 + $urandom % 3,
               $urandom % 2, $urandom % 8, 1 + $urandom % 3, 20 + $urandom % 81, 1'b1);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule